// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is a slave on a two-wire bus of up to 400 kHz. It gives a bus master access to ten byte-wide registers through a persistent register pointer. The clock and data lines come in as oversampled inputs from the pads. Each line passes through a synchronizer and a majority filter, and the block drives only an open-drain pull-down enable for the data line.

A transfer opens with a START and a 7-bit address. The address is the fixed nibble 1100 followed by three strap pins, and its last bit selects read or write. In a write, the first byte after the address is a command byte. Its low four bits load the pointer and bit 4 turns on auto-increment. Later bytes go to the register the pointer selects. Registers 2 to 9 live outside the block and receive single-cycle write strobes. Registers 0 and 1 are the low and high bytes of a 16-bit live input port, captured when the acknowledge clock falls. A read returns the byte the pointer selects.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The slave responds to nothing until a START, which is the data line falling while the clock line is high. A STOP, the data line rising while the clock line is high, returns it to idle with the data line released.
- R2: An address byte whose upper seven bits differ from {1100, strap_i[2:0]} gets no acknowledge, and the rest of that transfer is ignored.
- R3: On an address match the slave pulls the data line low for the ninth clock. In a write it acknowledges every byte that follows.
- R4: The first written byte after the address is the command byte. Bits [3:0] load the pointer and bit 4 sets auto-increment. After reset the pointer and the flag are both zero.
- R5: A data byte written while the pointer is between 2 and 9 produces exactly one wr_en_o pulse, carrying that index and the byte.
- R6: With auto-increment set, the pointer advances after each data byte read or written and wraps from 9 to 0. With it clear, the pointer stays fixed.
- R7: Writes while the pointer is 0, 1 or 10 to 15 are acknowledged but produce no strobe, and the input-port bytes read back unchanged.
- R8: A read returns port_i[7:0] for pointer 0, port_i[15:8] for pointer 1, rd_data_i for pointers 2 to 9, and 0x00 for pointers 10 to 15. Bits are sent MSB first.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing more until the next START.
- R10: The input port is sampled at the falling clock edge that ends each acknowledge bit that precedes a read byte.
- R11: A pulse of one system clock on either bus line is filtered out and does not register as an edge, a START or a STOP.
- R12: A synchronous active-high rst releases the data line and returns the bus state, the pointer and auto-increment to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Low three address bits |
| port_i | input | 16 | Live input port, low byte is register 0 |
| rd_data_i | input | 8 | Read data of the external register at ptr_o |
| ptr_o | output | 4 | Current register pointer |
| wr_en_o | output | 1 | One-cycle write strobe for registers 2 to 9 |
| wr_idx_o | output | 4 | Register index of the write |
| wr_data_o | output | 8 | Byte being written |

## Verification
The bench aims at the pointer wrap from 9 to 0 in both directions of transfer. A design that wrapped at 15 or skipped register 0 would return the wrong third byte or strobe a non-existent register. It writes to the input registers and to pointers past 9, where a wrong design would emit a strobe or corrupt a read. It changes the input port between the two acknowledge edges of a read, which exposes a slave that samples the port at the wrong time. It also sends a one-cycle clock glitch in the middle of a byte and a false START on an idle bus, after a master NACK, and through an asserted reset in mid-transfer. Each of these shifts bits, produces a spurious acknowledge or leaves the data line driven when the design is wrong.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
    localparam int REG_W      = 8;
    localparam int PTR_W      = 4;
    localparam int NUM_REGS   = 10;
    localparam int FIRST_EXT  = 2;
    localparam int STRAP_W    = 3;
    localparam int PORT_W     = 2 * REG_W;
    localparam int SYNC_DEPTH = 2;
    localparam int FILT_TAPS  = 3;
    localparam int BITCNT_W   = $clog2(REG_W + 1);
    localparam logic [3:0] ADDR_FIXED = 4'b1100;
    localparam int AI_BIT     = PTR_W;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK,
        S_WDAT, S_WACK, S_RDAT, S_RACK, S_WSTOP
    } st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic is_ext(input logic [PTR_W-1:0] p);
        return (int'(p) >= FIRST_EXT) && (int'(p) < NUM_REGS);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p, input logic ai);
        if (!ai) return p;
        if (int'(p) == NUM_REGS - 1) return '0;
        return p + 1'b1;
    endfunction
endpackage

// File: rtl/i2cp_glitch_filter.sv
module i2cp_glitch_filter #(
    parameter int SYNC = 2,
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int MAJ = TAPS / 2;

    logic [SYNC-1:0] sync_q;
    logic [TAPS-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], din};
            hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC-1]};
            dout   <= ($countones(hist_q) > MAJ);
        end
    end
endmodule

// File: rtl/i2cp_edge_detect.sv
module i2cp_edge_detect
    import i2cp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop  = scl_f & scl_q & ~sda_q & sda_f;
        ev.rise  = scl_f & ~scl_q;
        ev.fall  = ~scl_f & scl_q;
        ev.sda   = sda_f;
    end
endmodule

// File: rtl/i2cp_core.sv
module i2cp_core
    import i2cp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [PORT_W-1:0]  port_i,
    input  logic [REG_W-1:0]   rd_data_i,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [PTR_W-1:0]   wr_idx_o,
    output logic [REG_W-1:0]   wr_data_o,
    output logic [PTR_W-1:0]   ptr_o,
    output logic               ai_o,
    output st_e                st_o
);
    st_e                 st;
    logic [BITCNT_W-1:0] rcnt;
    logic [2:0]          tcnt;
    logic [REG_W-1:0]    sh, tx, src_byte;
    logic                rw, mack, receiving, byte_done;

    assign receiving = (st == S_ADDR) || (st == S_CMD) || (st == S_WDAT);
    assign byte_done = receiving && ev.fall && (int'(rcnt) == REG_W);

    always_comb begin
        if (ptr_o == '0)        src_byte = port_i[REG_W-1:0];
        else if (ptr_o == 4'd1) src_byte = port_i[PORT_W-1:REG_W];
        else if (is_ext(ptr_o)) src_byte = rd_data_i;
        else                    src_byte = '0;
    end

    // receive shifter and bit counter
    always_ff @(posedge clk) begin
        if (rst || ev.start) begin
            sh   <= '0;
            rcnt <= '0;
        end else if (receiving && ev.rise) begin
            sh   <= {sh[REG_W-2:0], ev.sda};
            rcnt <= rcnt + 1'b1;
        end else if (byte_done) begin
            rcnt <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            tcnt      <= '0;
            tx        <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            ptr_o     <= '0;
            ai_o      <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (ev.start) begin
                st       <= S_ADDR;
                sda_oe_o <= 1'b0;
            end else if (ev.stop) begin
                st       <= S_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (st)
                    S_ADDR: if (byte_done) begin
                        if (sh[REG_W-1:1] == {ADDR_FIXED, strap_i}) begin
                            rw       <= sh[0];
                            sda_oe_o <= 1'b1;
                            st       <= S_AACK;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                    S_AACK: if (ev.fall) begin
                        if (rw) begin
                            tx       <= src_byte;
                            sda_oe_o <= ~src_byte[REG_W-1];
                            tcnt     <= '0;
                            st       <= S_RDAT;
                        end else begin
                            sda_oe_o <= 1'b0;
                            st       <= S_CMD;
                        end
                    end
                    S_CMD: if (byte_done) begin
                        ptr_o    <= sh[PTR_W-1:0];
                        ai_o     <= sh[AI_BIT];
                        sda_oe_o <= 1'b1;
                        st       <= S_CACK;
                    end
                    S_CACK, S_WACK: if (ev.fall) begin
                        sda_oe_o <= 1'b0;
                        st       <= S_WDAT;
                    end
                    S_WDAT: if (byte_done) begin
                        if (is_ext(ptr_o)) begin
                            wr_en_o   <= 1'b1;
                            wr_idx_o  <= ptr_o;
                            wr_data_o <= sh;
                        end
                        ptr_o    <= ptr_next(ptr_o, ai_o);
                        sda_oe_o <= 1'b1;
                        st       <= S_WACK;
                    end
                    S_RDAT: if (ev.fall) begin
                        if (tcnt == 3'd7) begin
                            sda_oe_o <= 1'b0;
                            ptr_o    <= ptr_next(ptr_o, ai_o);
                            st       <= S_RACK;
                        end else begin
                            tx       <= {tx[REG_W-2:0], 1'b0};
                            sda_oe_o <= ~tx[REG_W-2];
                            tcnt     <= tcnt + 1'b1;
                        end
                    end
                    S_RACK: begin
                        if (ev.rise) mack <= ~ev.sda;
                        if (ev.fall) begin
                            if (mack) begin
                                tx       <= src_byte;
                                sda_oe_o <= ~src_byte[REG_W-1];
                                tcnt     <= '0;
                                st       <= S_RDAT;
                            end else begin
                                st <= S_WSTOP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign st_o = st;
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2cp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [PORT_W-1:0]  port_i,
    input  logic [REG_W-1:0]   rd_data_i,
    output logic [PTR_W-1:0]   ptr_o,
    output logic               wr_en_o,
    output logic [PTR_W-1:0]   wr_idx_o,
    output logic [REG_W-1:0]   wr_data_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw, filt;
    bus_ev_t              ev;
    logic                 ai_w;
    st_e                  st_w;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2cp_glitch_filter #(.SYNC(SYNC_DEPTH), .TAPS(FILT_TAPS)) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .dout(filt[g])
        );
    end

    i2cp_edge_detect u_edge (
        .clk  (clk),
        .rst  (rst),
        .scl_f(filt[0]),
        .sda_f(filt[1]),
        .ev   (ev)
    );

    i2cp_core u_core (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .strap_i  (strap_i),
        .port_i   (port_i),
        .rd_data_i(rd_data_i),
        .sda_oe_o (sda_oe_o),
        .wr_en_o  (wr_en_o),
        .wr_idx_o (wr_idx_o),
        .wr_data_o(wr_data_o),
        .ptr_o    (ptr_o),
        .ai_o     (ai_w),
        .st_o     (st_w)
    );
endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker
    import i2cp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_idx,
    input logic [PTR_W-1:0] ptr,
    input logic             ai,
    input logic             stop_evt,
    input st_e              st
);
    p_reset_defaults_r12: assert property (@(posedge clk)
        rst |=> (!sda_oe && ptr == '0 && !ai));

    p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> !sda_oe);

    p_wait_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_WSTOP) |-> !sda_oe);

    p_wr_single_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    p_wr_range_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) >= FIRST_EXT && int'(wr_idx) < NUM_REGS));

    p_ptr_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ai) |-> (ptr == wr_idx));

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ai) |-> (ptr == ((int'(wr_idx) == NUM_REGS - 1) ? '0 : wr_idx + 1'b1)));
endmodule

bind i2c_ptr_slave i2cp_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .sda_oe  (sda_oe_o),
    .wr_en   (wr_en_o),
    .wr_idx  (wr_idx_o),
    .ptr     (ptr_o),
    .ai      (ai_w),
    .stop_evt(ev.stop),
    .st      (st_w)
);

// File: tb/i2c_ptr_slave_tb_top.sv
module i2c_ptr_slave_tb_top;
    localparam int TQ = 25;
    localparam logic [7:0] AW = 8'hC6;
    localparam logic [7:0] AR = 8'hC7;
    localparam int NVEC = 4;
    // {register index, data byte}
    localparam logic [11:0] VEC [NVEC] = '{12'h25A, 12'h5C3, 12'h901, 12'h6FF};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, scl_drv, sda_drv, sda_bus;
    logic [2:0]  strap;
    logic [15:0] port;
    logic [7:0]  rd_data, wr_data;
    logic [3:0]  ptr, wr_idx;
    logic        sda_oe, wr_en;

    logic [7:0] regm [16] = '{default: 8'h00};
    int wr_cnt = 0;
    int nchk = 0;
    int nerr = 0;

    assign sda_bus = sda_drv & ~sda_oe;
    assign rd_data = regm[ptr];

    i2c_ptr_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .strap_i(strap), .port_i(port), .rd_data_i(rd_data), .ptr_o(ptr),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            regm[wr_idx] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq;
        repeat (TQ) @(negedge clk);
    endtask

    task automatic start_c;
        sda_drv = 1'b1; wq; scl_drv = 1'b1; wq; sda_drv = 1'b0; wq; scl_drv = 1'b0; wq;
    endtask

    task automatic stop_c;
        sda_drv = 1'b0; wq; scl_drv = 1'b1; wq; sda_drv = 1'b1; wq;
    endtask

    task automatic send_b(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i];
            if (glitch && i == 3) begin
                repeat (5) @(negedge clk);
                scl_drv = 1'b1; @(negedge clk); scl_drv = 1'b0;
                repeat (TQ - 6) @(negedge clk);
            end else begin
                wq;
            end
            scl_drv = 1'b1; wq; wq; scl_drv = 1'b0; wq;
        end
        sda_drv = 1'b1; wq; scl_drv = 1'b1; wq;
        ack = ~sda_bus;
        wq; scl_drv = 1'b0; wq;
    endtask

    task automatic recv_b(output logic [7:0] b, input bit mack);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq; scl_drv = 1'b1; wq; b[i] = sda_bus; wq; scl_drv = 1'b0;
        end
        wq; sda_drv = ~mack; wq; scl_drv = 1'b1; wq; wq; scl_drv = 1'b0; wq; sda_drv = 1'b1;
    endtask

    task automatic wr_cmd_data(input logic [7:0] cmd, input logic [7:0] d, output bit a0, a1, a2);
        start_c; send_b(AW, 0, a0); send_b(cmd, 0, a1); send_b(d, 0, a2); stop_c;
    endtask

    task automatic rd_single(output logic [7:0] d, output bit a);
        start_c; send_b(AR, 0, a); recv_b(d, 0); stop_c;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        bit a0, a1, a2, a3;
        logic [7:0] d, d2, d3;
        int base;
        rst = 1'b1; scl_drv = 1'b1; sda_drv = 1'b1; strap = 3'b011; port = 16'hB4D2;
        repeat (5) @(negedge clk);
        chk("R12 reset sda_oe", sda_oe, 0);
        chk("R4 reset pointer", ptr, 0);
        chk("R12 reset wr_en", wr_en, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R4: pointer 0 after reset selects the low input byte
        rd_single(d, a0);
        chk("R3 read address ack", a0, 1);
        chk("R4 read after reset", d, 8'hD2);

        // table of single writes and readbacks, auto-increment off
        for (int v = 0; v < NVEC; v++) begin
            base = wr_cnt;
            wr_cmd_data({4'h0, VEC[v][11:8]}, VEC[v][7:0], a0, a1, a2);
            chk("R3 write acks", {a0, a1, a2}, 3'b111);
            chk("R5 one strobe", wr_cnt - base, 1);
            chk("R5 strobe data", regm[VEC[v][11:8]], VEC[v][7:0]);
            chk("R6 pointer fixed", ptr, VEC[v][11:8]);
            rd_single(d, a0);
            chk("R8 readback", d, VEC[v][7:0]);
        end

        // R6: burst write from 8 wraps through 9 to 0
        base = wr_cnt;
        start_c; send_b(AW, 0, a0); send_b(8'h18, 0, a1);
        send_b(8'h11, 0, a2); send_b(8'h22, 0, a3);
        chk("R3 burst acks", {a0, a1, a2, a3}, 4'hF);
        send_b(8'h33, 0, a0); stop_c;
        chk("R7 input write acked", a0, 1);
        chk("R6 R7 burst strobes", wr_cnt - base, 2);
        chk("R6 reg8", regm[8], 8'h11);
        chk("R6 reg9", regm[9], 8'h22);
        chk("R6 pointer wrapped", ptr, 1);

        // R6: burst read from 8 wraps to input byte 0
        start_c; send_b(AW, 0, a0); send_b(8'h18, 0, a1); stop_c;
        start_c; send_b(AR, 0, a0);
        recv_b(d, 1); recv_b(d2, 1); recv_b(d3, 0); stop_c;
        chk("R6 burst read 8", d, 8'h11);
        chk("R6 burst read 9", d2, 8'h22);
        chk("R6 burst read wrap", d3, 8'hD2);

        // R7/R8: pointer past the last register
        base = wr_cnt;
        wr_cmd_data(8'h0C, 8'h77, a0, a1, a2);
        chk("R7 high pointer acked", {a0, a1, a2}, 3'b111);
        chk("R7 high pointer no strobe", wr_cnt - base, 0);
        rd_single(d, a0);
        chk("R8 high pointer reads zero", d, 8'h00);

        // R9: after NACK the slave stays off the bus
        start_c; send_b(AR, 0, a0); recv_b(d, 0); recv_b(d2, 0); stop_c;
        chk("R9 bus released after nack", d2, 8'hFF);

        // R7: write to input register 1 has no effect
        base = wr_cnt;
        wr_cmd_data(8'h01, 8'h99, a0, a1, a2);
        chk("R7 input write no strobe", wr_cnt - base, 0);
        rd_single(d, a0);
        chk("R7 input byte unchanged", d, 8'hB4);

        // R2: address mismatch
        start_c; send_b(8'hC0, 0, a0); send_b(8'h55, 0, a1); stop_c;
        chk("R2 mismatch no ack", {a0, a1}, 2'b00);
        strap = 3'b000;
        start_c; send_b(8'hC0, 0, a0); send_b(8'h06, 0, a1); stop_c;
        chk("R2 new strap matches", {a0, a1}, 2'b11);
        strap = 3'b011;

        // R1 R11: no START, and a one-cycle false START, get no ack
        send_b(AW, 0, a0);
        chk("R1 no start no ack", a0, 0);
        scl_drv = 1'b1; sda_drv = 1'b1; wq;
        sda_drv = 1'b0; @(negedge clk); sda_drv = 1'b1; wq;
        send_b(AW, 0, a0);
        chk("R11 glitch start ignored", a0, 0);

        // R11: one-cycle clock glitch inside a data byte
        base = wr_cnt;
        start_c; send_b(AW, 0, a0); send_b(8'h03, 0, a1); send_b(8'hA5, 1, a2); stop_c;
        chk("R11 glitch write acked", {a0, a1, a2}, 3'b111);
        chk("R11 glitch write data", regm[3], 8'hA5);
        chk("R11 glitch one strobe", wr_cnt - base, 1);

        // R10: port sampled at each acknowledge falling edge
        port = 16'h1E2F;
        start_c; send_b(AW, 0, a0); send_b(8'h10, 0, a1); stop_c;
        start_c; send_b(AR, 0, a0);
        port = 16'h7C6A;
        recv_b(d, 1); recv_b(d2, 0); stop_c;
        chk("R10 first byte from address ack", d, 8'h2F);
        chk("R10 second byte from master ack", d2, 8'h7C);

        // R12: reset in the middle of a write
        start_c; send_b(AW, 0, a0); send_b(8'h15, 0, a1);
        sda_drv = 1'b0; wq;
        rst = 1'b1; repeat (4) @(negedge clk);
        chk("R12 mid reset release", sda_oe, 0);
        chk("R12 mid reset pointer", ptr, 0);
        rst = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1; wq;
        start_c; send_b(AR, 0, a0); recv_b(d, 1); recv_b(d2, 0); stop_c;
        chk("R12 read after reset", d, 8'h6A);
        chk("R12 auto-increment cleared", d2, 8'h6A);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule